// File: doc/BRIEF.md
# Data Address Watch Unit

This unit sits beside a load/store pipeline and inspects every data access, given as a 32-bit address plus a flag that tells stores from loads. It first moves low addresses into the current process's slot: when the process-ID field is nonzero and the top seven address bits are all clear, the field is ORed into those bits. The relocated address is driven out unregistered so the pipeline can use it in the same cycle.

On the relocated address the unit then checks word alignment, when that check is enabled, and compares the address with two programmable watch addresses. A misaligned access gives a one-cycle abort strobe and loads the fault status and fault address registers. A watch match gives a one-cycle hit strobe and writes the data-watch entry code into a debug status word. All configuration goes through a small write-only register port. Taking the resulting exception is left to the surrounding core.

Top module: `dwatch_top`

## Requirements
- R1: When the process-ID field is nonzero and bits 31:25 of the access address are all zero, `reloc_addr` equals the address with the process-ID field ORed into bits 31:25, in the same cycle.
- R2: When the process-ID field is zero, or any of bits 31:25 of the access address is set, `reloc_addr` equals the access address unchanged.
- R3: With alignment checking enabled (bit 0 of register 1), a valid access whose relocated bits 1:0 are not both zero raises `abort_q` for exactly the next cycle; with checking disabled, or on an aligned address, no abort is raised.
- R4: On each abort, `fault_status` becomes FAULT_STATUS (default 32'h0000_0401) and `fault_addr` becomes the relocated faulting address; both hold until the next abort.
- R5: Each watch comparator has a 2-bit enable: 0 disables it, 1 matches stores only, 2 matches loads and stores, 3 matches loads only.
- R6: In normal mode, comparator 0 (enable in bits 1:0 of register 4) and comparator 1 (enable in bits 3:2) each match when the relocated address equals its watch address (registers 2 and 3) with bits 1:0 ignored.
- R7: In mask mode (bit 8 of register 4) only comparator 0 is active, and it compares address with watch address 0 only at the bit positions where watch address 1 holds zero.
- R8: A matching valid access raises `hit_q` for exactly the next cycle, and a single hit strobe when both comparators match.
- R9: On a hit, bits 4:2 of `dbg_status` take the entry code 3'b010 and all other bits keep their value; register 5 writes the whole word.
- R10: After reset all outputs and registers are zero; register 0 keeps only bits 31:25 of a write and register 4 ignores all bits other than 8 and 3:0.
- R11: Alignment check, fault address and watch comparison all use the relocated address.
- R12: When `acc_valid` is low no hit or abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 pid, 1 system control, 2 watch addr 0, 3 watch addr 1, 4 watch control, 5 debug status) |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_addr | input | 32 | Access address before relocation |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| reloc_addr | output | 32 | Relocated address (combinational) |
| abort_q | output | 1 | Alignment abort strobe, one cycle |
| fault_status | output | 32 | Captured fault status |
| fault_addr | output | 32 | Captured fault address |
| hit_q | output | 1 | Watch hit strobe, one cycle |
| dbg_status | output | 32 | Debug status word |

## Verification
The bench builds the unit with its default parameters: a 32-bit address with a seven-bit process field, the entry code at bits 4:2 and the mask-mode bit at position 8. With these values a single table row can set a process ID, two watch addresses and a control word, and so reach relocation into the process field, each of the four enable codes in both comparators, mask mode with partial masks, and the case where both comparators match. Directed tests then cover the alignment abort with and without relocation, fault register hold, partial update of the debug word and the field masking of the register port.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  localparam int AW      = 32;
  localparam int PIDW    = 7;
  localparam int NCMP    = 2;
  localparam int LOW_IGN = 2;

  localparam logic [2:0] SEL_PID   = 3'd0;
  localparam logic [2:0] SEL_SYS   = 3'd1;
  localparam logic [2:0] SEL_WA0   = 3'd2;
  localparam logic [2:0] SEL_WA1   = 3'd3;
  localparam logic [2:0] SEL_WCTL  = 3'd4;
  localparam logic [2:0] SEL_DBG   = 3'd5;

  typedef enum logic [1:0] {
    WEN_OFF   = 2'd0,
    WEN_STORE = 2'd1,
    WEN_ANY   = 2'd2,
    WEN_LOAD  = 2'd3
  } wen_e;

  // does the enable code accept this access direction
  function automatic logic wen_allows(input logic [1:0] en, input logic is_store);
    case (en)
      WEN_STORE: return is_store;
      WEN_ANY:   return 1'b1;
      WEN_LOAD:  return !is_store;
      default:   return 1'b0;
    endcase
  endfunction

  // equality restricted to the bits set in care
  function automatic logic masked_eq(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                     input logic [AW-1:0] care);
    return ((a ^ b) & care) == '0;
  endfunction

  // move a low address into the process slot
  function automatic logic [AW-1:0] relocate(input logic [AW-1:0] addr, input logic [PIDW-1:0] pid);
    logic [AW-1:0] r;
    r = addr;
    if (pid != '0 && addr[AW-1 -: PIDW] == '0)
      r[AW-1 -: PIDW] = pid;
    return r;
  endfunction
endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
  import dwatch_pkg::*;
#(
  parameter int MASK_BIT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [2:0]                sel,
  input  logic [AW-1:0]             wdata,
  output logic [PIDW-1:0]           pid,
  output logic                      align_en,
  output logic [NCMP-1:0][AW-1:0]   waddr,
  output logic [NCMP-1:0][1:0]      wen,
  output logic                      mask_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid       <= '0;
      align_en  <= 1'b0;
      waddr     <= '0;
      wen       <= '0;
      mask_mode <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_PID:  pid      <= wdata[AW-1 -: PIDW];
        SEL_SYS:  align_en <= wdata[0];
        SEL_WA0:  waddr[0] <= wdata;
        SEL_WA1:  waddr[1] <= wdata;
        SEL_WCTL: begin
          for (int i = 0; i < NCMP; i++) wen[i] <= wdata[2*i +: 2];
          mask_mode <= wdata[MASK_BIT];
        end
        default: ;
      endcase
    end
  end

  assert_wctl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_PID) |=> $stable(wen) && $stable(mask_mode));
endmodule

// File: rtl/dwatch_reloc.sv
module dwatch_reloc
  import dwatch_pkg::*;
(
  input  logic [PIDW-1:0] pid,
  input  logic [AW-1:0]   addr_in,
  output logic [AW-1:0]   addr_out
);
  always_comb addr_out = relocate(addr_in, pid);
endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
  import dwatch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          is_store,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] care_mask,
  input  logic [1:0]    en,
  input  logic          active,
  output logic          match
);
  logic dir_ok;
  logic addr_ok;

  always_comb begin
    dir_ok  = wen_allows(en, is_store);
    addr_ok = masked_eq(addr, ref_addr, care_mask);
    match   = active && dir_ok && addr_ok;
  end

  assert_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == WEN_OFF) |-> !match);
  assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == WEN_STORE && !is_store) |-> !match);
  assert_load_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en == WEN_LOAD && is_store) |-> !match);
endmodule

// File: rtl/dwatch_top.sv
module dwatch_top
  import dwatch_pkg::*;
#(
  parameter logic [31:0] FAULT_STATUS = 32'h0000_0401,
  parameter logic [2:0]  MOE_CODE     = 3'b010,
  parameter int          MOE_LSB      = 2,
  parameter int          MASK_BIT     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        acc_valid,
  input  logic [31:0] acc_addr,
  input  logic        acc_store,
  output logic [31:0] reloc_addr,
  output logic        abort_q,
  output logic [31:0] fault_status,
  output logic [31:0] fault_addr,
  output logic        hit_q,
  output logic [31:0] dbg_status
);
  localparam logic [AW-1:0] WORD_CARE = {{(AW-LOW_IGN){1'b1}}, {LOW_IGN{1'b0}}};

  logic [PIDW-1:0]          pid;
  logic                     align_en;
  logic [NCMP-1:0][AW-1:0]  waddr;
  logic [NCMP-1:0][1:0]     wen;
  logic                     mask_mode;
  logic [NCMP-1:0]          cmp_match;
  logic                     hit_now;
  logic                     misalign_now;

  dwatch_regs #(.MASK_BIT(MASK_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .pid(pid), .align_en(align_en), .waddr(waddr), .wen(wen), .mask_mode(mask_mode)
  );

  dwatch_reloc u_reloc (.pid(pid), .addr_in(acc_addr), .addr_out(reloc_addr));

  assert_reloc_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_addr[AW-PIDW-1:0] == acc_addr[AW-PIDW-1:0]);
  assert_reloc_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pid == '0 || acc_addr[AW-1 -: PIDW] != '0) |-> reloc_addr == acc_addr);

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam bit IS_BASE = (i == 0);
    logic [AW-1:0] care;
    logic          act;
    assign care = (mask_mode && IS_BASE) ? ~waddr[NCMP-1] : WORD_CARE;
    assign act  = !(mask_mode && !IS_BASE);
    dwatch_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .addr(reloc_addr), .is_store(acc_store),
      .ref_addr(waddr[i]), .care_mask(care), .en(wen[i]), .active(act),
      .match(cmp_match[i])
    );
  end

  assign hit_now      = acc_valid && (|cmp_match);
  assign misalign_now = acc_valid && align_en && (|reloc_addr[LOW_IGN-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q        <= 1'b0;
      abort_q      <= 1'b0;
      fault_status <= '0;
      fault_addr   <= '0;
      dbg_status   <= '0;
    end else begin
      hit_q   <= hit_now;
      abort_q <= misalign_now;
      if (misalign_now) begin
        fault_status <= FAULT_STATUS;
        fault_addr   <= reloc_addr;
      end
      if (cfg_we && cfg_sel == SEL_DBG) dbg_status <= cfg_wdata;
      if (hit_now) dbg_status[MOE_LSB +: 3] <= MOE_CODE;
    end
  end

  assert_abort_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !align_en) |=> !abort_q);
  assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> fault_addr == $past(reloc_addr) && fault_status == FAULT_STATUS);
  assert_fault_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !misalign_now |=> $stable(fault_addr));
  assert_mask_only0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mask_mode && wen[0] == WEN_OFF) |=> !hit_q);
  assert_moe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> dbg_status[MOE_LSB +: 3] == MOE_CODE);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit_q && !abort_q);
endmodule

// File: tb/sim_dwatch_top.sv
module sim_dwatch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_store = 1'b0;
  logic [31:0] reloc_addr, fault_status, fault_addr, dbg_status;
  logic        abort_q, hit_q;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dwatch_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_store(acc_store),
    .reloc_addr(reloc_addr), .abort_q(abort_q), .fault_status(fault_status),
    .fault_addr(fault_addr), .hit_q(hit_q), .dbg_status(dbg_status)
  );

  typedef struct packed {
    logic [8:0]  wc;
    logic [31:0] a0;
    logic [31:0] a1;
    logic [6:0]  pid;
    logic [31:0] addr;
    logic        st;
    logic        hit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{9'h000, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1000, 1'b0, 1'b0}, // R5 off
    '{9'h002, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1002, 1'b1, 1'b1}, // R6 low bits ignored
    '{9'h001, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1000, 1'b0, 1'b0}, // R5 store-only, load
    '{9'h001, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1000, 1'b1, 1'b1}, // R5 store-only, store
    '{9'h003, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1000, 1'b1, 1'b0}, // R5 load-only, store
    '{9'h003, 32'h0000_1000, 32'h0, 7'h00, 32'h0000_1000, 1'b0, 1'b1}, // R5 load-only, load
    '{9'h008, 32'h0000_1000, 32'h0000_2000, 7'h00, 32'h0000_2003, 1'b0, 1'b1}, // R6 comp1
    '{9'h008, 32'h0000_1000, 32'h0000_2000, 7'h00, 32'h0000_2004, 1'b0, 1'b0}, // R6 comp1 miss
    '{9'h102, 32'h0000_1000, 32'h0000_00FF, 7'h00, 32'h0000_10AB, 1'b0, 1'b1}, // R7 masked hit
    '{9'h102, 32'h0000_1000, 32'h0000_00FF, 7'h00, 32'h0000_20AB, 1'b0, 1'b0}, // R7 masked miss
    '{9'h108, 32'h0000_1000, 32'h0000_3000, 7'h00, 32'h0000_3000, 1'b0, 1'b0}, // R7 comp1 inactive
    '{9'h002, 32'h0A00_1000, 32'h0, 7'h05, 32'h0000_1000, 1'b0, 1'b1}, // R11 relocated hit
    '{9'h002, 32'h0A00_1000, 32'h0, 7'h05, 32'h0200_1000, 1'b0, 1'b0}, // R2 no relocation
    '{9'h00A, 32'h0000_4000, 32'h0000_4000, 7'h00, 32'h0000_4000, 1'b1, 1'b1}  // R8 both match
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one access; on return we are one negedge later with strobes visible
  task automatic access(input logic [31:0] a, input logic st);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_store = st;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_reloc(input logic [31:0] a, input logic [6:0] p);
    if (p == 7'd0 || a[31:25] != 7'd0) return a;
    return a | {p, 25'd0};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset hit", {31'd0, hit_q}, 32'd0);
    chk("R10 reset abort", {31'd0, abort_q}, 32'd0);
    chk("R10 reset fault_status", fault_status, 32'd0);
    chk("R10 reset fault_addr", fault_addr, 32'd0);
    chk("R10 reset dbg", dbg_status, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {VT[i].pid, 25'd0});
      wr(3'd2, VT[i].a0);
      wr(3'd3, VT[i].a1);
      wr(3'd4, {23'd0, VT[i].wc});
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = VT[i].addr; acc_store = VT[i].st;
      #1;
      chk("R1/R2 reloc row", reloc_addr, exp_reloc(VT[i].addr, VT[i].pid));
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R5/R6/R7/R8 hit row", {31'd0, hit_q}, {31'd0, VT[i].hit});
    end

    // R8: single pulse when both comparators match (config of last row)
    @(negedge clk);
    chk("R8 pulse ends", {31'd0, hit_q}, 32'd0);

    // R12: no access, no strobe
    @(negedge clk);
    acc_addr = 32'h0000_4000; acc_store = 1'b1;
    @(negedge clk);
    chk("R12 idle no hit", {31'd0, hit_q}, 32'd0);

    // R9: partial update of debug word
    wr(3'd5, 32'hFFFF_FFE3);
    chk("R9 dbg write", dbg_status, 32'hFFFF_FFE3);
    access(32'h0000_4000, 1'b0);
    chk("R9 hit", {31'd0, hit_q}, 32'd1);
    chk("R9 dbg entry code", dbg_status, 32'hFFFF_FFEB);

    // R10: field masking of register port
    wr(3'd4, 32'hFFFF_FE00);
    access(32'h0000_4000, 1'b0);
    chk("R10 wctl ignored bits", {31'd0, hit_q}, 32'd0);
    wr(3'd0, 32'h01FF_FFFF);
    @(negedge clk);
    acc_addr = 32'h0000_0040;
    #1;
    chk("R10 pid ignored bits", reloc_addr, 32'h0000_0040);

    // R3/R4: alignment abort
    wr(3'd1, 32'h1);
    access(32'h0000_0101, 1'b0);
    chk("R3 abort raised", {31'd0, abort_q}, 32'd1);
    chk("R4 fault addr", fault_addr, 32'h0000_0101);
    chk("R4 fault status", fault_status, 32'h0000_0401);
    @(negedge clk);
    chk("R3 abort one cycle", {31'd0, abort_q}, 32'd0);
    access(32'h0000_0104, 1'b1);
    chk("R3 aligned no abort", {31'd0, abort_q}, 32'd0);
    chk("R4 fault addr held", fault_addr, 32'h0000_0101);

    // R11: fault address is relocated
    wr(3'd0, {7'h05, 25'd0});
    access(32'h0000_0102, 1'b1);
    chk("R11 abort relocated", {31'd0, abort_q}, 32'd1);
    chk("R11 fault addr relocated", fault_addr, 32'h0A00_0102);

    // R3: check disabled
    wr(3'd1, 32'h0);
    access(32'h0000_0103, 1'b0);
    chk("R3 disabled no abort", {31'd0, abort_q}, 32'd0);

    // R12: misaligned address without valid
    wr(3'd1, 32'h1);
    @(negedge clk);
    acc_addr = 32'h0000_0003;
    @(negedge clk);
    chk("R12 idle no abort", {31'd0, abort_q}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule